// File: doc/BRIEF.md
# Clear-on-read event counter bank

This block keeps four short hardware event counters: received frames, format errors, locatable errors and tokens. It also keeps an interrupt event register and an interrupt mask register. The frame classifier and the error evaluator drive one-cycle increment strobes into the counters. Other hardware sources set bits in the event register. A host reads and writes the bank through a simple synchronous port with one address, one read strobe and one write strobe.

The frame, format-error and locatable-error counters clear themselves when the host reads them. This lets software add each reading into its own wide total. If an increment lands in the same cycle as a clearing read, the counter ends that cycle at one, so no event is lost. The counters are short on purpose. They only need to cover the events that arrive during one long interrupt latency.

A single level interrupt output is high whenever an event bit and its matching mask bit are both one. There are two resets. The power-up reset clears everything. The soft reset clears the counters and the event register but keeps the mask.

Top module: `evcnt_bank`

## Requirements
- R1: A read with `host_rd` high at address 0 (frames), 1 (format errors) or 2 (locatable errors) returns the counter's current value on `host_rdata` in that same cycle, and the counter is zero after that clock edge.
- R2: When a clearing read of a counter and that counter's increment strobe fall in the same cycle, the counter holds 1 after the edge.
- R3: Each counter is CNT_W bits wide (8 by default) and wraps modulo 2^CNT_W: 300 increments leave 44.
- R4: The token counter sits at address 3, and host reads never clear it.
- R5: Event register at address 4. A high `evt_set` bit sets the matching bit. Writing one to a bit clears it, and writing zero leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: The mask register sits at address 5. Any value written there reads back unchanged.
- R7: `irq` is high exactly when some bit is one in both the event and the mask register, one cycle after either register changes.
- R8: `rst_n` low clears every counter, the event register and the mask. `mac_rst` high for a cycle clears the counters and the event register but leaves the mask unchanged.
- R9: Host writes to addresses 0 to 3 change no counter. Reads of addresses 6 and 7 return zero.
- R10: Each counter adds exactly one for every cycle its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| mac_rst | input | 1 | Soft reset, synchronous, active high |
| inc_frame | input | 1 | Frame counted strobe |
| inc_lost | input | 1 | Format error strobe |
| inc_err | input | 1 | Locatable error strobe |
| inc_token | input | 1 | Token seen strobe |
| evt_set | input | N_EVT | Event bit set strobes |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe, clears the addressed counter |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | CNT_W | Write data |
| host_rdata | output | CNT_W | Read data, valid in the read cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters, CNT_W = 8 and N_EVT = 8. With an 8-bit counter, a 300-cycle strobe burst crosses the wrap point within a short run. With eight event bits, the bench can use separate bit positions for the set-versus-clear race, the mask gating and the write-one-to-clear check.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_FRM  = 3'd0,
    A_LOST = 3'd1,
    A_ERR  = 3'd2,
    A_TOK  = 3'd3,
    A_EVT  = 3'd4,
    A_MSK  = 3'd5
  } reg_addr_e;
  localparam int N_CNT = 4;
endpackage

// File: rtl/evcnt_dec.sv
module evcnt_dec
  import evcnt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [N_CNT-1:0]  clr_hit,
  output logic              wr_evt,
  output logic              wr_msk
);
  always_comb begin
    clr_hit = '0;
    if (rd) begin
      case (addr)
        A_FRM:   clr_hit[0] = 1'b1;
        A_LOST:  clr_hit[1] = 1'b1;
        A_ERR:   clr_hit[2] = 1'b1;
        default: clr_hit = '0;
      endcase
    end
    wr_evt = wr && (addr == A_EVT);
    wr_msk = wr && (addr == A_MSK);
  end
endmodule

// File: rtl/evcnt_ctr.sv
module evcnt_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] cnt_next(input logic [W-1:0] cur,
                                            input logic inc_i,
                                            input logic clr_i);
    logic [W-1:0] base;
    base = clr_i ? '0 : cur;
    return base + W'(inc_i);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (srst) cnt <= '0;
    else           cnt <= cnt_next(cnt, inc, clr);
  end

  // R1: a clearing read with no increment leaves zero
  p_clr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc && !srst) |=> (cnt == '0));
  // R2: a clear colliding with an increment leaves one
  p_clr_inc_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc && !srst) |=> (cnt == W'(1)));
  // R10: no strobe, no clear, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc && !srst) |=> $stable(cnt));
endmodule

// File: rtl/evcnt_irq.sv
module evcnt_irq #(
  parameter int N_EVT = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [N_EVT-1:0] evt_set,
  input  logic             wr_evt,
  input  logic             wr_msk,
  input  logic [DW-1:0]    wdata,
  output logic [N_EVT-1:0] evt_q,
  output logic [N_EVT-1:0] msk_q,
  output logic             irq
);
  logic [N_EVT-1:0] w1c;
  assign w1c = wr_evt ? wdata[N_EVT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    evt_q <= '0;
    else if (srst) evt_q <= '0;
    else           evt_q <= (evt_q & ~w1c) | evt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msk_q <= '0;
    else if (wr_msk) msk_q <= wdata[N_EVT-1:0];
  end

  assign irq = |(evt_q & msk_q);

  // R8: soft reset leaves the mask alone
  p_mask_keep_soft_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !wr_msk) |=> $stable(msk_q));
  // R5: a set strobe always lands, even against a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && (|evt_set)) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));
  // R5: write-one-to-clear drops bits that are not being set
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !srst) |=> ((evt_q & $past(w1c & ~evt_set)) == '0));
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_EVT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_rst,
  input  logic              inc_frame,
  input  logic              inc_lost,
  input  logic              inc_err,
  input  logic              inc_token,
  input  logic [N_EVT-1:0]  evt_set,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [CNT_W-1:0]  host_wdata,
  output logic [CNT_W-1:0]  host_rdata,
  output logic              irq
);
  logic [N_CNT-1:0] inc_vec;
  logic [N_CNT-1:0] clr_hit;
  logic             wr_evt, wr_msk;
  logic [CNT_W-1:0] cnt_q [N_CNT];
  logic [N_EVT-1:0] evt_q, msk_q;

  assign inc_vec = {inc_token, inc_err, inc_lost, inc_frame};

  evcnt_dec u_dec (
    .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .clr_hit(clr_hit), .wr_evt(wr_evt), .wr_msk(wr_msk)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    evcnt_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .srst(mac_rst),
      .inc(inc_vec[i]), .clr(clr_hit[i]), .cnt(cnt_q[i])
    );
  end

  evcnt_irq #(.N_EVT(N_EVT), .DW(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .srst(mac_rst), .evt_set(evt_set),
    .wr_evt(wr_evt), .wr_msk(wr_msk), .wdata(host_wdata),
    .evt_q(evt_q), .msk_q(msk_q), .irq(irq)
  );

  always_comb begin
    case (host_addr)
      A_FRM:   host_rdata = cnt_q[0];
      A_LOST:  host_rdata = cnt_q[1];
      A_ERR:   host_rdata = cnt_q[2];
      A_TOK:   host_rdata = cnt_q[3];
      A_EVT:   host_rdata = CNT_W'(evt_q);
      A_MSK:   host_rdata = CNT_W'(msk_q);
      default: host_rdata = '0;
    endcase
  end

  // R4: reads never clear the token counter
  p_tok_no_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mac_rst && !inc_token) |=> $stable(cnt_q[3]));
  // R9: a host write alone never moves a counter
  p_wr_no_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && !mac_rst && inc_vec == '0) |=>
      ($stable(cnt_q[0]) && $stable(cnt_q[1]) && $stable(cnt_q[2])));
endmodule

// File: tb/sim_evcnt_bank.sv
module sim_evcnt_bank;
  localparam int CLK_PER = 10;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, mac_rst = 1'b0;
  logic       inc_frame = 0, inc_lost = 0, inc_err = 0, inc_token = 0;
  logic [7:0] evt_set = '0;
  logic [2:0] host_addr = '0;
  logic       host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  evcnt_bank u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // read at addr: returns rdata in the strobe cycle; the clear lands on the next edge
  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); host_addr = a; host_rd = 1; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); chk("R8 reset value", v, 0); end
    chk("R7 irq after reset", {7'b0, irq}, 0);
  endtask

  task automatic t_count();
    logic [7:0] v;
    @(negedge clk); inc_frame = 1; repeat (5) @(negedge clk); inc_frame = 0;
    @(negedge clk); inc_err = 1; @(negedge clk); inc_err = 0;
    rd(3'd0, v); chk("R10 frame count", v, 5);
    rd(3'd0, v); chk("R1 frame cleared", v, 0);
    rd(3'd2, v); chk("R10 error count", v, 1);
    rd(3'd2, v); chk("R1 error cleared", v, 0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    @(negedge clk); inc_lost = 1; repeat (3) @(negedge clk);
    host_addr = 3'd1; host_rd = 1; #1 v = host_rdata;
    @(negedge clk); inc_lost = 0; host_rd = 0;
    chk("R2 pre-clear value", v, 3);
    rd(3'd1, v); chk("R2 collision leaves one", v, 1);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    @(negedge clk); inc_lost = 1; repeat (300) @(negedge clk); inc_lost = 0;
    rd(3'd1, v); chk("R3 wrap 300 -> 44", v, 44);
  endtask

  task automatic t_token();
    logic [7:0] v;
    @(negedge clk); inc_token = 1; repeat (4) @(negedge clk); inc_token = 0;
    rd(3'd3, v); chk("R4 token count", v, 4);
    rd(3'd3, v); chk("R4 token kept after read", v, 4);
  endtask

  task automatic t_wr_ignored();
    logic [7:0] v;
    @(negedge clk); inc_frame = 1; repeat (2) @(negedge clk); inc_frame = 0;
    wr(3'd0, 8'hAA); wr(3'd3, 8'h55);
    rd(3'd0, v); chk("R9 write to counter ignored", v, 2);
    rd(3'd3, v); chk("R9 token write ignored", v, 4);
    rd(3'd6, v); chk("R9 unmapped read", v, 0);
    rd(3'd7, v); chk("R9 unmapped read 7", v, 0);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    @(negedge clk); evt_set = 8'h04; @(negedge clk); evt_set = 0;
    rd(3'd4, v); chk("R5 event set", v, 8'h04);
    chk("R7 masked off", {7'b0, irq}, 0);
    wr(3'd5, 8'hC4);
    rd(3'd5, v); chk("R6 mask readback", v, 8'hC4);
    chk("R7 irq high", {7'b0, irq}, 1);
    wr(3'd4, 8'h00); rd(3'd4, v); chk("R5 write zero no effect", v, 8'h04);
    wr(3'd4, 8'h04);
    chk("R7 irq low after clear", {7'b0, irq}, 0);
    rd(3'd4, v); chk("R5 w1c", v, 0);
    @(negedge clk); evt_set = 8'h02; host_addr = 3'd4; host_wdata = 8'h02; host_wr = 1;
    @(negedge clk); evt_set = 0; host_wr = 0;
    rd(3'd4, v); chk("R5 set beats clear", v, 8'h02);
    chk("R7 unmasked bit no irq", {7'b0, irq}, 0);
  endtask

  task automatic t_soft();
    logic [7:0] v;
    @(negedge clk); inc_err = 1; evt_set = 8'h40; @(negedge clk); inc_err = 0; evt_set = 0;
    chk("R7 irq on masked bit", {7'b0, irq}, 1);
    @(negedge clk); mac_rst = 1; @(negedge clk); mac_rst = 0;
    rd(3'd2, v); chk("R8 soft clears counter", v, 0);
    rd(3'd3, v); chk("R8 soft clears token", v, 0);
    rd(3'd4, v); chk("R8 soft clears events", v, 0);
    rd(3'd5, v); chk("R8 mask survives soft", v, 8'hC4);
    chk("R7 irq low after soft", {7'b0, irq}, 0);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(3'd5, v); chk("R8 power-up clears mask", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_count(); t_collide(); t_wrap(); t_token();
    t_wr_ignored(); t_irq(); t_soft();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule